// File: doc/BRIEF.md
# Seconds Real-Time Clock with Keyed Write Gate

This block keeps time in whole seconds for a chip that has a slow timebase of about 32 kHz. The slow clock enters as a one-cycle enable strobe, `slow_en`, in the main clock domain. A programmable regulator counts these strobes and makes one tick every N strobes. While counting is enabled, each tick adds one to a 32-bit seconds counter and sets a tick flag. A 32-bit alarm register is compared against the counter. A match sets an alarm flag, and the alarm flag and the tick flag can each drive the interrupt output through their own enable bits.

The host uses a simple register bus. Reads are combinational. A write takes effect only after two steps. First the host writes a key to the unlock register. Then it issues the real write, which the block holds for four slow strobes before committing. A write-ready flag in the control register shows whether the block can accept a write. A scratchpad register keeps whatever software last wrote there, so firmware can check after power-up whether the clock contents can be trusted. A write to the seconds register can race with a tick, so software should read the counter twice and take the value only when both reads agree.

The write gate is a three-state machine. LOCKED is the state after reset and after every commit. LOCKED goes to OPEN on a correct key write. OPEN goes to BUSY on any write to a register other than the unlock register, and that write is captured. BUSY goes to LOCKED on the fourth slow strobe, and that is the edge where the captured write commits.

Top module: `rtc_core`

## Requirements
- R1: After reset, control reads 0x80, seconds, alarm, scratchpad and unlock read 0, and the regulator reads its default of 32767.
- R2: The register offsets are fixed: control 0x00, seconds 0x04, alarm 0x08, regulator 0x0C (low 16 bits), scratchpad 0x34, unlock 0x3C (state in bit 31). The control bits are: bit 0 run, bit 1 alarm flag, bit 2 alarm enable, bit 3 alarm interrupt enable, bit 4 tick interrupt enable, bit 6 tick flag, bit 7 write-ready (read-only). The scratchpad returns the last value committed to it.
- R3: Writing 0xA55A in the low 16 bits to 0x3C while write-ready is set sets unlock bit 31. Any other value written there is ignored. A write to any other register while bit 31 is clear is discarded.
- R4: An accepted write clears write-ready at once. The register keeps its old value until the fourth `slow_en` strobe. At that edge the new value lands, write-ready sets again and unlock bit 31 clears.
- R5: A write issued while write-ready is clear is discarded.
- R6: While run is set, a tick happens every (regulator+1) strobes. Each tick adds one to seconds and sets the tick flag.
- R7: While run is clear, seconds and the regulator phase hold.
- R8: A committed write to the seconds register wins over a tick on the same edge.
- R9: When a tick makes seconds equal to the alarm value and alarm enable is set, the alarm flag sets.
- R10: A committed control write clears each flag whose bit in the write is 0 and leaves the flag unchanged where the bit is 1. A flag set by a tick on the commit edge stays set.
- R11: `irq` is high when (alarm flag AND alarm interrupt enable) OR (tick flag AND tick interrupt enable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_en | input | 1 | One-cycle strobe per slow-clock period |
| bus_wr | input | 1 | Write request, one cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the commit edge of a control write that coincides with a tick, where the clear from software and the set from the tick meet on one edge. The bench reaches it by counting strobes. It loads a regulator period of four, lets a tick happen, and then issues a control write while run is still set. The four busy strobes then end exactly on the next tick. A write issued during the busy window and a commit that happens with run already cleared are also placed by strobe count.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int OFF_CTRL = 8'h00;
    localparam int OFF_SEC  = 8'h04;
    localparam int OFF_ALRM = 8'h08;
    localparam int OFF_REGU = 8'h0C;
    localparam int OFF_SCRA = 8'h34;
    localparam int OFF_UNLK = 8'h3C;

    localparam logic [15:0] UNLOCK_KEY = 16'hA55A;

    localparam int B_RUN   = 0;
    localparam int B_AFLG  = 1;
    localparam int B_AEN   = 2;
    localparam int B_AIE   = 3;
    localparam int B_TIE   = 4;
    localparam int B_TFLG  = 6;
    localparam int B_READY = 7;

    typedef enum logic [1:0] {
        WG_LOCKED = 2'd0,
        WG_OPEN   = 2'd1,
        WG_BUSY   = 2'd2
    } wg_state_t;
endpackage

// File: rtl/rtc_regulator.sv
module rtc_regulator #(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_en,
    input  logic             run,
    input  logic             clear,
    input  logic [REG_W-1:0] limit,
    output logic             tick
);
    logic [REG_W-1:0] cnt;

    always_comb begin
        tick = slow_en && run && (cnt == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (slow_en && run) begin
            cnt <= tick ? '0 : cnt + 1'b1;
        end
    end

    // R7
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(slow_en && run) && !clear) |=> $stable(cnt));
endmodule

// File: rtl/rtc_wrgate.sv
module rtc_wrgate
    import rtc_pkg::*;
#(
    parameter int AW         = 8,
    parameter int DW         = 32,
    parameter int BUSY_TICKS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slow_en,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          ready,
    output logic          wen,
    output logic          commit,
    output logic [AW-1:0] c_addr,
    output logic [DW-1:0] c_data
);
    localparam int CW = $clog2(BUSY_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(BUSY_TICKS - 1);
    localparam logic [AW-1:0] UNLK_A = AW'(OFF_UNLK);

    wg_state_t     state, nxt;
    logic [CW-1:0] cnt;
    logic          key_hit, reg_wr, last_strobe;

    always_comb begin
        key_hit     = wr && (addr == UNLK_A) && (wdata[15:0] == UNLOCK_KEY);
        reg_wr      = wr && (addr != UNLK_A);
        last_strobe = slow_en && (cnt == LAST);
    end

    always_comb begin
        nxt = state;
        unique case (state)
            WG_LOCKED: if (key_hit)              nxt = WG_OPEN;
            WG_OPEN:   if (reg_wr)               nxt = WG_BUSY;
            WG_BUSY:   if (last_strobe)          nxt = WG_LOCKED;
            default:                             nxt = WG_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WG_LOCKED;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            c_addr <= '0;
            c_data <= '0;
        end else if (state == WG_OPEN && reg_wr) begin
            cnt    <= '0;
            c_addr <= addr;
            c_data <= wdata;
        end else if (state == WG_BUSY && slow_en) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        ready  = (state != WG_BUSY);
        wen    = (state == WG_OPEN);
        commit = (state == WG_BUSY) && last_strobe;
    end

    // R3
    locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WG_LOCKED && reg_wr) |=> (state == WG_LOCKED));
    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WG_BUSY && !slow_en) |=> (state == WG_BUSY && $stable(c_data)));
    // R4
    relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (ready && !wen));
endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int AW         = 8,
    parameter int REG_W      = 16,
    parameter int BUSY_TICKS = 4,
    parameter int REG_DEF    = 32767
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slow_en,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          irq
);
    localparam int DW = 32;

    logic          ready, wen, commit, tick;
    logic [AW-1:0] c_addr;
    logic [DW-1:0] c_data;

    logic [DW-1:0]    sec, alarm, scratch;
    logic [REG_W-1:0] regu;
    logic             run, aflg, aen, aie, tie, tflg;
    logic             wr_ctrl, wr_sec, wr_alrm, wr_regu, wr_scra;
    logic             set_af;
    logic [DW-1:0]    sec_inc;

    rtc_wrgate #(.AW(AW), .DW(DW), .BUSY_TICKS(BUSY_TICKS)) u_gate (
        .clk(clk), .rst_n(rst_n), .slow_en(slow_en),
        .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .ready(ready), .wen(wen), .commit(commit),
        .c_addr(c_addr), .c_data(c_data)
    );

    rtc_regulator #(.REG_W(REG_W)) u_regu (
        .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .run(run),
        .clear(wr_regu), .limit(regu), .tick(tick)
    );

    always_comb begin
        wr_ctrl = commit && (c_addr == AW'(OFF_CTRL));
        wr_sec  = commit && (c_addr == AW'(OFF_SEC));
        wr_alrm = commit && (c_addr == AW'(OFF_ALRM));
        wr_regu = commit && (c_addr == AW'(OFF_REGU));
        wr_scra = commit && (c_addr == AW'(OFF_SCRA));
        sec_inc = sec + 1'b1;
        set_af  = tick && !wr_sec && aen && (sec_inc == alarm);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec     <= '0;
            alarm   <= '0;
            scratch <= '0;
            regu    <= REG_W'(REG_DEF);
        end else begin
            if (wr_sec)       sec <= c_data;
            else if (tick)    sec <= sec_inc;
            if (wr_alrm) alarm   <= c_data;
            if (wr_scra) scratch <= c_data;
            if (wr_regu) regu    <= c_data[REG_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run  <= 1'b0;
            aen  <= 1'b0;
            aie  <= 1'b0;
            tie  <= 1'b0;
            aflg <= 1'b0;
            tflg <= 1'b0;
        end else if (wr_ctrl) begin
            run  <= c_data[B_RUN];
            aen  <= c_data[B_AEN];
            aie  <= c_data[B_AIE];
            tie  <= c_data[B_TIE];
            aflg <= (aflg && c_data[B_AFLG]) || set_af;
            tflg <= (tflg && c_data[B_TFLG]) || tick;
        end else begin
            aflg <= aflg || set_af;
            tflg <= tflg || tick;
        end
    end

    always_comb begin
        irq = (aflg && aie) || (tflg && tie);
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(OFF_CTRL): begin
                bus_rdata[B_RUN]   = run;
                bus_rdata[B_AFLG]  = aflg;
                bus_rdata[B_AEN]   = aen;
                bus_rdata[B_AIE]   = aie;
                bus_rdata[B_TIE]   = tie;
                bus_rdata[B_TFLG]  = tflg;
                bus_rdata[B_READY] = ready;
            end
            AW'(OFF_SEC):  bus_rdata = sec;
            AW'(OFF_ALRM): bus_rdata = alarm;
            AW'(OFF_REGU): bus_rdata = DW'(regu);
            AW'(OFF_SCRA): bus_rdata = scratch;
            AW'(OFF_UNLK): bus_rdata[31] = wen;
            default:       bus_rdata = '0;
        endcase
    end

    // R6
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_sec) |=> (sec == $past(sec) + 32'd1));
    // R8
    sec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sec |=> (sec == $past(c_data)));
    // R9
    alarm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aflg) |-> $past(tick));
endmodule

// File: tb/sim_rtc_core.sv
`timescale 1ns/1ps
module sim_rtc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rtc_core u0 (
        .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); slow_en = 1'b1;
            @(negedge clk); slow_en = 1'b0;
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        wr(8'h3C, 32'h0000_A55A);
        wr(a, d);
        pulse(4);
    endtask

    task automatic expect_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic t_reset();
        expect_reg("R1 ctrl", 8'h00, 32'h80);
        expect_reg("R1 sec", 8'h04, 32'h0);
        expect_reg("R1 alarm", 8'h08, 32'h0);
        expect_reg("R1 regu", 8'h0C, 32'd32767);
        expect_reg("R1 scratch", 8'h34, 32'h0);
        expect_reg("R1 unlock", 8'h3C, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_lock();
        wr(8'h34, 32'hDEAD_BEEF);
        expect_reg("R3 locked write dropped", 8'h34, 32'h0);
        expect_reg("R3 ready stays", 8'h00, 32'h80);
        wr(8'h3C, 32'h0000_1234);
        expect_reg("R3 wrong key", 8'h3C, 32'h0);
        wr(8'h3C, 32'h0000_A55A);
        expect_reg("R3 key opens", 8'h3C, 32'h8000_0000);
    endtask

    task automatic t_commit();
        wr(8'h34, 32'h1234_5678);
        expect_reg("R4 ready low", 8'h00, 32'h00);
        pulse(3);
        expect_reg("R4 old value held", 8'h34, 32'h0);
        wr(8'h34, 32'hCAFE_0000);
        pulse(1);
        expect_reg("R4 R2 scratch lands", 8'h34, 32'h1234_5678);
        expect_reg("R4 ready back", 8'h00, 32'h80);
        expect_reg("R4 relocked", 8'h3C, 32'h0);
        pulse(4);
        expect_reg("R5 busy write dropped", 8'h34, 32'h1234_5678);
    endtask

    task automatic t_count();
        reg_write(8'h0C, 32'd2);
        reg_write(8'h00, 32'h01);
        pulse(3);
        expect_reg("R6 first tick", 8'h04, 32'd1);
        expect_reg("R6 tick flag", 8'h00, 32'hC1);
        pulse(6);
        expect_reg("R6 three ticks", 8'h04, 32'd3);
        reg_write(8'h00, 32'h00);
        expect_reg("R6 tick in busy window", 8'h04, 32'd4);
        expect_reg("R10 tick flag cleared", 8'h00, 32'h80);
        pulse(5);
        expect_reg("R7 stopped", 8'h04, 32'd4);
        reg_write(8'h04, 32'd10);
        expect_reg("R8 seconds load", 8'h04, 32'd10);
    endtask

    task automatic t_alarm();
        reg_write(8'h0C, 32'd3);
        reg_write(8'h08, 32'd12);
        reg_write(8'h00, 32'h0D);
        pulse(4);
        expect_reg("R9 no early alarm", 8'h04, 32'd11);
        check("R11 irq low before alarm", {31'b0, irq}, 32'h0);
        pulse(4);
        expect_reg("R9 alarm flag", 8'h00, 32'hCF);
        check("R11 alarm irq", {31'b0, irq}, 32'h1);
        reg_write(8'h00, 32'h0C);
        expect_reg("R10 tick on commit edge", 8'h04, 32'd13);
        expect_reg("R10 af cleared tf kept", 8'h00, 32'hCC);
        check("R11 irq after clear", {31'b0, irq}, 32'h0);
        reg_write(8'h00, 32'h50);
        expect_reg("R10 keep tick flag", 8'h00, 32'hD0);
        check("R11 tick irq", {31'b0, irq}, 32'h1);
        reg_write(8'h00, 32'h10);
        expect_reg("R10 clear tick flag", 8'h00, 32'h90);
        check("R11 tick irq gone", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_lock();
        t_commit();
        t_count();
        t_alarm();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule